// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands. Each operand is a sign bit, an unsigned biased exponent and an unsigned fractional mantissa whose most significant bit weighs one half. The two operands are held in an accumulator register and an operand register. They pass through a zero check and an exponent alignment that moves one bit per cycle. A signed-magnitude mantissa add follows, with complement correction, and then a normalization that also moves one bit per cycle. The result is left in the accumulator and presented on the result ports.

Operands enter through a valid/ready handshake. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so a new operation cannot start while one is in flight. The result is held on `res_*` with `out_valid` high until the consumer raises `out_ready`. This back-pressure freezes the block in its finished state, and the result stays unchanged until it is taken. No rounding, special values or exception signalling are provided. Instead, an exponent that would leave its range saturates and raises `res_sat`.

Top module: `fp_addsub_seq`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are taken only on an edge with `in_valid` and `in_ready` both high. `in_ready` stays 0 from that edge until the result is taken. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all `res_*` outputs hold their values, and `in_valid` is ignored.
- R3: If the second operand's mantissa is zero, the result is the first operand unchanged (sign, exponent and mantissa), with `res_sat` 0.
- R4: If only the first operand's mantissa is zero, the result is the second operand's exponent and mantissa. Its sign is the second operand's sign, inverted when `op_sub` is 1.
- R5: With `op_sub` = 1 the second operand's sign (1 = negative) is inverted before the signed add; with `op_sub` = 0 it is used as given.
- R6: While the exponents differ, the mantissa with the smaller exponent moves right by one bit and its exponent increases by one, one step per cycle. Bits shifted out are dropped.
- R7: When the effective signs match and the mantissa sum carries out, the sum moves right with the carry entering the top bit, and the exponent increases by one.
- R8: When the effective signs differ and the first magnitude is below the second, the mantissa becomes the magnitude of the difference and the result sign is the first operand's sign inverted.
- R9: A computed mantissa of zero gives a result of sign 0, exponent 0 and mantissa 0.
- R10: A nonzero computed mantissa whose top bit is 0 moves left one bit per cycle, and the exponent decreases by one each step, until the top bit is 1.
- R11: A carry at the maximum exponent gives an all-ones mantissa at the maximum exponent with `res_sat` 1. A normalization that reaches exponent 0 with the top bit still 0 stops there with `res_sat` 1. Otherwise `res_sat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are valid |
| in_ready | output | 1 | Block is idle and accepts operands |
| op_sub | input | 1 | 1 = subtract second operand, 0 = add |
| a_sign | input | 1 | First operand sign, 1 = negative |
| a_exp | input | EW | First operand biased exponent |
| a_man | input | MW | First operand fractional mantissa |
| b_sign | input | 1 | Second operand sign, 1 = negative |
| b_exp | input | EW | Second operand biased exponent |
| b_man | input | MW | Second operand fractional mantissa |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | EW | Result biased exponent |
| res_man | output | MW | Result mantissa |
| res_sat | output | 1 | Exponent saturated during the operation |

## Verification
The main function is tried with a set of operand pairs. Equal exponents with matching signs exercise the carry shift. Operands a few exponents apart check the alignment direction, both for the first and for the second operand being smaller. A gap large enough to shift a mantissa to zero is included as well. Subtractions with the first magnitude larger and then smaller separate the plain difference from the complement-and-flip path. An exact cancellation shows the cleared zero. Unnormalized inputs drive several normalization steps. Either mantissa being zero is tried with add and with subtract, which checks the zero paths and where the sign inversion is applied. Operands at the top and bottom of the exponent range show the saturation. A stalled consumer with new operands offered during the stall checks the hold-and-ignore rules.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZCHK,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_DONE
  } fpas_state_e;
endpackage

// File: rtl/fpas_mant_alu.sv
module fpas_mant_alu #(
  parameter int MW = 8
) (
  input  logic [MW-1:0] acc_man,
  input  logic [MW-1:0] opr_man,
  input  logic          acc_sign,
  input  logic          opr_sign,
  output logic          same_sign,
  output logic          carry,
  output logic          sign_flip,
  output logic [MW-1:0] mag
);
  logic [MW:0] sum_w;

  always_comb begin
    same_sign = (acc_sign == opr_sign);
    carry     = 1'b0;
    sign_flip = 1'b0;
    if (same_sign) begin
      sum_w = {1'b0, acc_man} + {1'b0, opr_man};
      carry = sum_w[MW];
      mag   = sum_w[MW-1:0];
    end else begin
      sum_w = {1'b0, acc_man} + {1'b0, ~opr_man} + (MW+1)'(1);
      // no end carry means the accumulator magnitude was the smaller one
      sign_flip = ~sum_w[MW];
      mag = sum_w[MW] ? sum_w[MW-1:0] : (~sum_w[MW-1:0] + MW'(1));
    end
  end

  // R7 / R8: a carry and a sign flip never come out of the same add
  always_comb begin
    a_r8_flip_only_on_diff: assert (!(carry && sign_flip));
  end
endmodule

// File: rtl/fpas_exp_unit.sv
module fpas_exp_unit #(
  parameter int EW = 6
) (
  input  logic [EW-1:0] acc_exp,
  input  logic [EW-1:0] opr_exp,
  output logic          acc_lt,
  output logic          acc_gt,
  output logic          acc_at_max,
  output logic          acc_at_zero,
  output logic [EW-1:0] acc_inc,
  output logic [EW-1:0] acc_dec,
  output logic [EW-1:0] opr_inc
);
  localparam logic [EW-1:0] EXP_MAX = '1;

  always_comb begin
    acc_lt      = acc_exp < opr_exp;
    acc_gt      = acc_exp > opr_exp;
    acc_at_max  = acc_exp == EXP_MAX;
    acc_at_zero = acc_exp == '0;
    acc_inc     = acc_exp + EW'(1);
    acc_dec     = acc_exp - EW'(1);
    opr_inc     = opr_exp + EW'(1);
  end
endmodule

// File: rtl/fp_addsub_seq.sv
module fp_addsub_seq
  import fpas_pkg::*;
#(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          op_sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_man,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_man,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          res_sign,
  output logic [EW-1:0] res_exp,
  output logic [MW-1:0] res_man,
  output logic          res_sat
);
  localparam logic [MW-1:0] MAN_ONES = '1;
  localparam int            MSB      = MW - 1;

  fpas_state_e   st;
  logic          acc_sign, opr_sign, sat_q;
  logic [EW-1:0] acc_exp, opr_exp;
  logic [MW-1:0] acc_man, opr_man;

  logic          same_sign, carry, sign_flip;
  logic [MW-1:0] mag;
  logic          acc_lt, acc_gt, acc_at_max, acc_at_zero;
  logic [EW-1:0] acc_inc, acc_dec, opr_inc;

  fpas_mant_alu #(.MW(MW)) u_alu (
    .acc_man  (acc_man),
    .opr_man  (opr_man),
    .acc_sign (acc_sign),
    .opr_sign (opr_sign),
    .same_sign(same_sign),
    .carry    (carry),
    .sign_flip(sign_flip),
    .mag      (mag)
  );

  fpas_exp_unit #(.EW(EW)) u_exp (
    .acc_exp    (acc_exp),
    .opr_exp    (opr_exp),
    .acc_lt     (acc_lt),
    .acc_gt     (acc_gt),
    .acc_at_max (acc_at_max),
    .acc_at_zero(acc_at_zero),
    .acc_inc    (acc_inc),
    .acc_dec    (acc_dec),
    .opr_inc    (opr_inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      acc_sign <= 1'b0;
      acc_exp  <= '0;
      acc_man  <= '0;
      opr_sign <= 1'b0;
      opr_exp  <= '0;
      opr_man  <= '0;
      sat_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          acc_sign <= a_sign;
          acc_exp  <= a_exp;
          acc_man  <= a_man;
          opr_sign <= b_sign ^ op_sub;   // subtraction becomes a signed add
          opr_exp  <= b_exp;
          opr_man  <= b_man;
          sat_q    <= 1'b0;
          st       <= ST_ZCHK;
        end
        ST_ZCHK: begin
          if (opr_man == '0) begin
            st <= ST_DONE;
          end else if (acc_man == '0) begin
            acc_sign <= opr_sign;
            acc_exp  <= opr_exp;
            acc_man  <= opr_man;
            st       <= ST_DONE;
          end else begin
            st <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (acc_lt) begin
            acc_man <= acc_man >> 1;
            acc_exp <= acc_inc;
          end else if (acc_gt) begin
            opr_man <= opr_man >> 1;
            opr_exp <= opr_inc;
          end else begin
            st <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (same_sign && carry) begin
            if (acc_at_max) begin
              acc_man <= MAN_ONES;
              sat_q   <= 1'b1;
            end else begin
              acc_man <= {1'b1, mag[MW-1:1]};
              acc_exp <= acc_inc;
            end
            st <= ST_DONE;
          end else begin
            acc_man <= mag;
            if (sign_flip) acc_sign <= ~acc_sign;
            st <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (acc_man == '0) begin
            acc_sign <= 1'b0;
            acc_exp  <= '0;
            st       <= ST_DONE;
          end else if (acc_man[MSB]) begin
            st <= ST_DONE;
          end else if (acc_at_zero) begin
            sat_q <= 1'b1;
            st    <= ST_DONE;
          end else begin
            acc_man <= acc_man << 1;
            acc_exp <= acc_dec;
          end
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign res_sign  = acc_sign;
  assign res_exp   = acc_exp;
  assign res_man   = acc_man;
  assign res_sat   = sat_q;

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_man) && $stable(res_exp)
                                   && $stable(res_sign) && $stable(res_sat)));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r6_align_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ALIGN && acc_exp < opr_exp) |=> (acc_exp == $past(acc_exp) + EW'(1)));

  a_r9_zero_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORM && acc_man == '0) |=> (out_valid && res_exp == '0 && !res_sign));

  a_r10_norm_left: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORM && acc_man != '0 && !acc_man[MSB] && acc_exp != '0)
      |=> (acc_exp == $past(acc_exp) - EW'(1)));

  a_r11_sat_low_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORM && acc_man != '0 && !acc_man[MSB] && acc_exp == '0)
      |=> (out_valid && res_sat));
endmodule

// File: tb/fp_addsub_seq_bench.sv
`timescale 1ns/1ps
module fp_addsub_seq_bench;
  localparam int MW = 8;
  localparam int EW = 6;

  typedef struct packed {
    logic          op;
    logic          as;
    logic [EW-1:0] ae;
    logic [MW-1:0] am;
    logic          bs;
    logic [EW-1:0] be;
    logic [MW-1:0] bm;
    logic          rs;
    logic [EW-1:0] re;
    logic [MW-1:0] rm;
    logic          rsat;
  } vec_t;

  localparam int NV = 12;
  // op 1 = subtract, sign 1 = negative, mantissa MSB weighs one half
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 6'd10, 8'h80, 1'b0, 6'd10, 8'h80, 1'b0, 6'd11, 8'h80, 1'b0}, // R7 carry
    '{1'b0, 1'b0, 6'd5,  8'hC0, 1'b0, 6'd3,  8'h80, 1'b0, 6'd5,  8'hE0, 1'b0}, // R6 shift second
    '{1'b1, 1'b0, 6'd5,  8'hC0, 1'b0, 6'd5,  8'h80, 1'b0, 6'd4,  8'h80, 1'b0}, // R5 R10
    '{1'b1, 1'b0, 6'd5,  8'h80, 1'b0, 6'd5,  8'hC0, 1'b1, 6'd4,  8'h80, 1'b0}, // R8
    '{1'b1, 1'b1, 6'd7,  8'hA0, 1'b1, 6'd7,  8'hA0, 1'b0, 6'd0,  8'h00, 1'b0}, // R9
    '{1'b0, 1'b1, 6'd9,  8'h90, 1'b0, 6'd3,  8'h00, 1'b1, 6'd9,  8'h90, 1'b0}, // R3
    '{1'b1, 1'b0, 6'd2,  8'h00, 1'b0, 6'd12, 8'hB0, 1'b1, 6'd12, 8'hB0, 1'b0}, // R4 sub
    '{1'b0, 1'b0, 6'd3,  8'h80, 1'b1, 6'd5,  8'h80, 1'b1, 6'd4,  8'hC0, 1'b0}, // R6 R8
    '{1'b0, 1'b0, 6'd63, 8'h80, 1'b0, 6'd63, 8'h80, 1'b0, 6'd63, 8'hFF, 1'b1}, // R11 high
    '{1'b1, 1'b0, 6'd1,  8'h81, 1'b0, 6'd1,  8'h80, 1'b0, 6'd0,  8'h02, 1'b1}, // R11 low
    '{1'b0, 1'b0, 6'd20, 8'h80, 1'b0, 6'd2,  8'h80, 1'b0, 6'd20, 8'h80, 1'b0}, // R6 lost bits
    '{1'b0, 1'b0, 6'd10, 8'h10, 1'b0, 6'd10, 8'h10, 1'b0, 6'd8,  8'h80, 1'b0}  // R10
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          op_sub = 1'b0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_man = '0, b_man = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          res_sign, res_sat;
  logic [EW-1:0] res_exp;
  logic [MW-1:0] res_man;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fp_addsub_seq #(.MW(MW), .EW(EW)) u_fp_addsub_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man), .out_valid(out_valid),
    .out_ready(out_ready), .res_sign(res_sign), .res_exp(res_exp),
    .res_man(res_man), .res_sat(res_sat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    op_sub = v.op; a_sign = v.as; a_exp = v.ae; a_man = v.am;
    b_sign = v.bs; b_exp = v.be; b_man = v.bm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    for (int k = 0; k < 200 && !out_valid; k++) @(negedge clk);
  endtask

  task automatic check_res(input vec_t v, input string tag);
    logic [MW+EW+1:0] act, exp;
    act = {res_sign, res_exp, res_man, res_sat};
    exp = {v.rs, v.re, v.rm, v.rsat};
    chk(out_valid && act == exp, tag, 32'(act), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      chk(in_ready === 1'b0, $sformatf("R2 busy vec %0d", i), 32'(in_ready), 32'd0);
      wait_out();
      check_res(VEC[i], $sformatf("R3-R11 table vec %0d", i));
      @(negedge clk);
    end

    // R2 back-pressure: result holds and new operands are ignored
    out_ready = 1'b0;
    issue(VEC[7]);
    wait_out();
    in_valid = 1'b1;
    op_sub = 1'b0; a_sign = 1'b0; a_exp = 6'd30; a_man = 8'hF0;
    b_sign = 1'b0; b_exp = 6'd30; b_man = 8'hF0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_res(VEC[7], "R2 held while stalled");
      chk(in_ready === 1'b0, "R2 not ready while stalled", 32'(in_ready), 32'd0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R2 released to idle",
        32'({out_valid, in_ready}), 32'b01);

    // R4 with add keeps the second operand's sign; R5 sign inversion on add is absent
    issue('{1'b0, 1'b1, 6'd4, 8'h00, 1'b1, 6'd6, 8'hA0, 1'b1, 6'd6, 8'hA0, 1'b0});
    wait_out();
    check_res('{1'b0, 1'b1, 6'd4, 8'h00, 1'b1, 6'd6, 8'hA0, 1'b1, 6'd6, 8'hA0, 1'b0},
              "R4 R5 zero first operand add");
    @(negedge clk);

    // R3 both zero: first operand returned as is, subtract ignored
    issue('{1'b1, 1'b1, 6'd17, 8'h00, 1'b0, 6'd40, 8'h00, 1'b1, 6'd17, 8'h00, 1'b0});
    wait_out();
    check_res('{1'b1, 1'b1, 6'd17, 8'h00, 1'b0, 6'd40, 8'h00, 1'b1, 6'd17, 8'h00, 1'b0},
              "R3 both mantissas zero");
    @(negedge clk);

    // R7 R5: subtract of a negative equals add, carry path
    issue('{1'b1, 1'b0, 6'd20, 8'hC0, 1'b1, 6'd20, 8'hC0, 1'b0, 6'd21, 8'hC0, 1'b0});
    wait_out();
    check_res('{1'b1, 1'b0, 6'd20, 8'hC0, 1'b1, 6'd20, 8'hC0, 1'b0, 6'd21, 8'hC0, 1'b0},
              "R7 R5 sub of negative");
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule